// File: doc/BRIEF.md
# Memory-to-Memory Byte Copy Engine

This block copies a run of bytes from one memory region to another. It pairs two channel register sets. Channel 0 holds the source address and a 16-bit count. Channel 1 holds the destination address and its own 16-bit count. The block drives a synchronous read port and a separate write port.

Software loads the four registers through a small configuration port while the engine is idle. It then sets the copy-enable command input. A request on channel 0, once latched as pending, starts the copy. For each byte the engine takes three cycles:

1. It presents the source address on the read port.
2. On the next cycle it captures the returned byte into a holding register.
3. On the cycle after that it writes the held byte to the destination address.

After the write, both addresses step up by one and both counts step down by one. The copy stops after the first write that takes either count from zero to all ones. When it stops, the engine raises the terminal-count flags of both channels, clears both pending requests, drops its hold request and returns to idle. The flags stay set until a status read. The address and count registers keep their final values, so software can inspect them afterwards.

Top module: `m2m_copy_engine`

## Requirements
- R1: After reset the engine is idle with `hold_req`, `mem_rd_en` and `mem_wr_en` low. `tc_flags` and `req_pending` are 0, and all four address and count registers read 0.
- R2: A copy starts only from idle, and only when `cmd_m2m_en` is high and `req_pending[0]` is set. A pending request on channel 1 alone, or a pending channel 0 request while `cmd_m2m_en` is low, leaves the engine idle. In that case `hold_req` stays 0.
- R3: Each byte takes three cycles:
  - a read cycle, with `mem_rd_en` high and `mem_rd_addr` equal to the source address;
  - a capture cycle, in which `mem_rd_data` is taken into the holding register;
  - a write cycle, with `mem_wr_en` high, `mem_wr_addr` equal to the destination address and `mem_wr_data` equal to the captured byte.

  The two strobes are never high together.
- R4: After each write cycle, both addresses increment by one, wrapping from 0xFFFF to 0x0000. Both counts decrement by one.
- R5: The copy ends after the write in which either count goes from 0 to 0xFFFF. Programmed counts of A (source) and B (destination) therefore move min(A,B)+1 bytes.
- R6: In the cycle after the last write:
  - `hold_req` is 0 and the engine is idle;
  - `tc_flags` is 2'b11;
  - `req_pending` is 2'b00.

  `hold_req` is high in every read, capture and write cycle.
- R7: A cycle with `stat_rd` high clears `tc_flags` to 0 on the next edge. If completion happens in the same cycle, the set wins.
- R8: `cfg_we` loads `cfg_wdata` into the register picked by `cfg_sel`: 0 is source address, 1 is source count, 2 is destination address, 3 is destination count. The load happens only while the engine is idle. A configuration write during a copy has no effect. The registers keep their final values after completion.
- R9: A one-cycle high on `drq[i]` sets `req_pending[i]`, which stays set until the next completion clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_m2m_en | input | 1 | Copy-mode command enable |
| drq | input | 2 | Request pulses for channels 0 and 1 |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select (0 src addr, 1 src count, 2 dst addr, 3 dst count) |
| cfg_wdata | input | 16 | Configuration write value |
| stat_rd | input | 1 | Status read strobe, clears terminal-count flags |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 16 | Memory write address |
| mem_wr_data | output | 8 | Memory write data |
| hold_req | output | 1 | Bus hold request, high while copying |
| tc_flags | output | 2 | Terminal-count flags for channels 0 and 1 |
| req_pending | output | 2 | Latched pending requests |
| src_addr | output | 16 | Channel 0 (source) address register |
| src_count | output | 16 | Channel 0 (source) count register |
| dst_addr | output | 16 | Channel 1 (destination) address register |
| dst_count | output | 16 | Channel 1 (destination) count register |

## Verification
The bench runs three copies whose counts are chosen to probe the stop condition:
- In one copy the source count runs out first. A design that waited for both counts, or stopped at zero instead of on the wrap, would move the wrong number of bytes.
- In another copy the destination count is the smaller one. The source address also starts at 0xFFFF, so an address that failed to wrap would read from beyond the 16-bit range.
- In the third copy both counts are zero, so exactly one byte moves.

The bench also sends a lone channel 1 request and a channel 0 request while copying is disabled; a loose start condition would begin a copy on either. It writes configuration during a copy, where a missing idle guard would corrupt the addresses. Every written byte is compared with the byte read two cycles before, which catches a holding register loaded one cycle late.

// File: rtl/m2m_pkg.sv
package m2m_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_LAT  = 2'd2,
        ST_WR   = 2'd3
    } m2m_state_e;

    localparam int NUM_CH    = 2;
    localparam int SEL_W     = 2;
    localparam int SEL_ADDR  = 0;
    localparam int SEL_COUNT = 1;

endpackage

// File: rtl/m2m_chan_regs.sv
module m2m_chan_regs #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cnt,
    output logic              wrap_next
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } chan_t;

    chan_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ld_addr) r_d.addr = addr_val;
        if (ld_cnt)  r_d.cnt  = cnt_val;
        if (step) begin
            r_d.addr = r_q.addr + ADDR_W'(1);
            r_d.cnt  = r_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign addr      = r_q.addr;
    assign cnt       = r_q.cnt;
    assign wrap_next = (r_q.cnt == '0);

    // R4: one step moves the address up and the count down by exactly one
    a_r4_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (addr == $past(addr) + ADDR_W'(1)) && (cnt == $past(cnt) - CNT_W'(1)));

    // R8: without a load or step the registers hold
    a_r8_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld_addr && !ld_cnt) |=> $stable(addr) && $stable(cnt));

endmodule

// File: rtl/m2m_seq.sv
module m2m_seq
    import m2m_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              last,
    input  logic [DATA_W-1:0] rd_data,
    output m2m_state_e        state,
    output logic [DATA_W-1:0] temp
);

    typedef struct packed {
        m2m_state_e        st;
        logic [DATA_W-1:0] tmp;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: if (start) s_d.st = ST_RD;
            ST_RD:   s_d.st = ST_LAT;
            ST_LAT: begin
                s_d.tmp = rd_data;
                s_d.st  = ST_WR;
            end
            ST_WR:   s_d.st = last ? ST_IDLE : ST_RD;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, tmp: '0};
        else        s_q <= s_d;
    end

    assign state = s_q.st;
    assign temp  = s_q.tmp;

    // R3: read, capture and write follow each other in that order
    a_r3_rd_then_lat: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD) |=> (state == ST_LAT));
    a_r3_lat_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LAT) |=> (state == ST_WR));

    // R2: leaving idle needs a start
    a_r2_idle_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> (state == ST_IDLE));

endmodule

// File: rtl/m2m_status.sv
module m2m_status #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] drq,
    input  logic           done,
    input  logic           clr,
    output logic [NCH-1:0] tc,
    output logic [NCH-1:0] req
);

    typedef struct packed {
        logic [NCH-1:0] tc;
        logic [NCH-1:0] req;
    } stat_t;

    stat_t t_d, t_q;

    always_comb begin
        t_d     = t_q;
        t_d.req = t_q.req | drq;
        if (clr) t_d.tc = '0;
        if (done) begin
            t_d.tc  = '1;
            t_d.req = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign tc  = t_q.tc;
    assign req = t_q.req;

    // R6: completion sets both flags and empties the pending requests
    a_r6_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (tc == '1) && (req == '0));

    // R7: a status read without completion leaves the flags clear
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !done) |=> (tc == '0));

    // R9: a request pulse is remembered
    a_r9_req_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (drq[0] && !done) |=> req[0]);

endmodule

// File: rtl/m2m_copy_engine.sv
module m2m_copy_engine
    import m2m_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_m2m_en,
    input  logic [1:0]        drq,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [15:0]       cfg_wdata,
    input  logic              stat_rd,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              hold_req,
    output logic [1:0]        tc_flags,
    output logic [1:0]        req_pending,
    output logic [ADDR_W-1:0] src_addr,
    output logic [CNT_W-1:0]  src_count,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  dst_count
);

    localparam int SRC = 0;
    localparam int DST = 1;

    logic [NUM_CH-1:0][ADDR_W-1:0] ch_addr;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt;
    logic [NUM_CH-1:0]             ch_wrap;
    m2m_state_e                    state;
    logic [DATA_W-1:0]             temp;
    logic                          idle, step, last, start;

    assign idle  = (state == ST_IDLE);
    assign step  = (state == ST_WR);
    assign last  = step && (|ch_wrap);
    assign start = cmd_m2m_en && req_pending[SRC];

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        logic ld_a, ld_c;
        assign ld_a = cfg_we && idle && (cfg_sel == SEL_W'(2*gi + SEL_ADDR));
        assign ld_c = cfg_we && idle && (cfg_sel == SEL_W'(2*gi + SEL_COUNT));

        m2m_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld_addr   (ld_a),
            .ld_cnt    (ld_c),
            .addr_val  (ADDR_W'(cfg_wdata)),
            .cnt_val   (CNT_W'(cfg_wdata)),
            .step      (step),
            .addr      (ch_addr[gi]),
            .cnt       (ch_cnt[gi]),
            .wrap_next (ch_wrap[gi])
        );
    end

    m2m_seq #(.DATA_W(DATA_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .last    (last),
        .rd_data (mem_rd_data),
        .state   (state),
        .temp    (temp)
    );

    m2m_status #(.NCH(NUM_CH)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .drq   (drq),
        .done  (last),
        .clr   (stat_rd),
        .tc    (tc_flags),
        .req   (req_pending)
    );

    assign mem_rd_en   = (state == ST_RD);
    assign mem_rd_addr = ch_addr[SRC];
    assign mem_wr_en   = step;
    assign mem_wr_addr = ch_addr[DST];
    assign mem_wr_data = temp;
    assign hold_req    = !idle;
    assign src_addr    = ch_addr[SRC];
    assign src_count   = ch_cnt[SRC];
    assign dst_addr    = ch_addr[DST];
    assign dst_count   = ch_cnt[DST];

    // R3: strobes are exclusive
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R3: written byte is the byte returned one cycle earlier
    a_r3_wdata_source: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wr_data == $past(mem_rd_data)));

    // R5, R6: a write with a zero count ends the copy
    a_r6_end_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && (src_count == '0 || dst_count == '0)) |=> !hold_req && (tc_flags == 2'b11));

    // R5: a write with both counts nonzero continues with a read
    a_r5_continue: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && src_count != '0 && dst_count != '0) |=> mem_rd_en);

    // R2: a copy begins only with the enable and a channel 0 request
    a_r2_start_cond: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_req) |-> $past(cmd_m2m_en && req_pending[0]));

endmodule

// File: tb/sim_m2m_copy_engine.sv
module sim_m2m_copy_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_m2m_en;
    logic [1:0]  drq;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [15:0] cfg_wdata;
    logic        stat_rd;
    logic        mem_rd_en, mem_wr_en, hold_req;
    logic [15:0] mem_rd_addr, mem_wr_addr;
    logic [7:0]  mem_rd_data, mem_wr_data;
    logic [1:0]  tc_flags, req_pending;
    logic [15:0] src_addr, src_count, dst_addr, dst_count;

    always #10 clk = ~clk;

    m2m_copy_engine u0 (.*);

    int vecs = 0;
    int errs = 0;
    int nbytes = 0;
    bit done_flag = 0;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // memory: data one cycle after the address
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= pat(mem_rd_addr);

    // reference model
    int          m_st = 0;
    logic [15:0] m_sa = 0, m_sc = 0, m_da = 0, m_dc = 0;
    logic [7:0]  m_tmp = 0;
    logic [1:0]  m_tc = 0, m_req = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_sa = 0; m_sc = 0; m_da = 0; m_dc = 0;
            m_tmp = 0; m_tc = 0; m_req = 0;
        end else begin
            logic [1:0] nreq, ntc;
            nreq = m_req | drq;
            ntc  = stat_rd ? 2'b00 : m_tc;
            case (m_st)
                0: begin
                    if (cfg_we) begin
                        case (cfg_sel)
                            2'd0: m_sa = cfg_wdata;
                            2'd1: m_sc = cfg_wdata;
                            2'd2: m_da = cfg_wdata;
                            default: m_dc = cfg_wdata;
                        endcase
                    end
                    if (cmd_m2m_en && m_req[0]) m_st = 1;
                end
                1: m_st = 2;
                2: begin m_tmp = pat(m_sa); m_st = 3; end
                default: begin
                    m_sa = m_sa + 16'd1; m_da = m_da + 16'd1;
                    m_sc = m_sc - 16'd1; m_dc = m_dc - 16'd1;
                    if (m_sc == 16'hFFFF || m_dc == 16'hFFFF) begin
                        ntc = 2'b11; nreq = 2'b00; m_st = 0;
                    end else m_st = 1;
                end
            endcase
            m_tc = ntc; m_req = nreq;
        end
        #5;
        if (rst_n) begin
            chk("R3 mem_rd_en", 32'(mem_rd_en), 32'(m_st == 1));
            if (m_st == 1) chk("R3 mem_rd_addr", 32'(mem_rd_addr), 32'(m_sa));
            chk("R3 mem_wr_en", 32'(mem_wr_en), 32'(m_st == 3));
            if (m_st == 3) begin
                chk("R3 mem_wr_addr", 32'(mem_wr_addr), 32'(m_da));
                chk("R3 mem_wr_data", 32'(mem_wr_data), 32'(m_tmp));
            end
            if (mem_wr_en) nbytes++;
            chk("R6 hold_req", 32'(hold_req), 32'(m_st != 0));
            chk("R7 tc_flags", 32'(tc_flags), 32'(m_tc));
            chk("R9 req_pending", 32'(req_pending), 32'(m_req));
            chk("R4 src_addr", 32'(src_addr), 32'(m_sa));
            chk("R4 src_count", 32'(src_count), 32'(m_sc));
            chk("R4 dst_addr", 32'(dst_addr), 32'(m_da));
            chk("R4 dst_count", 32'(dst_count), 32'(m_dc));
        end
    end

    task automatic cfg(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_drq(input logic [1:0] m);
        @(negedge clk);
        drq = m;
        @(negedge clk);
        drq = 2'b00;
    endtask

    task automatic wait_start();
        for (int i = 0; i < 50 && !hold_req; i++) @(negedge clk);
        chk("R2 copy started", 32'(hold_req), 32'd1);
    endtask

    task automatic wait_end();
        for (int i = 0; i < 2000 && hold_req; i++) @(negedge clk);
        chk("R6 copy ended", 32'(hold_req), 32'd0);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        errs++;
        $display("FAIL watchdog R6 actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cmd_m2m_en = 1'b0; drq = 2'b00; cfg_we = 1'b0;
        cfg_sel = 2'd0; cfg_wdata = 16'd0; stat_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 hold_req", 32'(hold_req), 32'd0);
        chk("R1 strobes", 32'({mem_rd_en, mem_wr_en}), 32'd0);
        chk("R1 tc_flags", 32'(tc_flags), 32'd0);
        chk("R1 req_pending", 32'(req_pending), 32'd0);
        chk("R1 regs", 32'(src_addr | src_count | dst_addr | dst_count), 32'd0);

        // run 1: source count runs out first
        cfg(2'd0, 16'h0100); cfg(2'd1, 16'd3);
        cfg(2'd2, 16'h0200); cfg(2'd3, 16'd5);
        pulse_drq(2'b01);
        repeat (4) @(negedge clk);
        chk("R2 no start while disabled", 32'(hold_req), 32'd0);
        chk("R9 request held", 32'(req_pending), 32'b01);
        nbytes = 0;
        cmd_m2m_en = 1'b1;
        wait_start();
        wait_end();
        chk("R5 byte count run1", 32'(nbytes), 32'd4);
        chk("R6 tc both", 32'(tc_flags), 32'b11);
        chk("R6 requests cleared", 32'(req_pending), 32'b00);
        chk("R8 final src_addr", 32'(src_addr), 32'h0104);
        chk("R8 final src_count", 32'(src_count), 32'hFFFF);
        chk("R8 final dst_addr", 32'(dst_addr), 32'h0204);
        chk("R8 final dst_count", 32'(dst_count), 32'h0001);
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        chk("R7 status read clears", 32'(tc_flags), 32'd0);

        // run 2: channel 1 alone must not start; dst smaller; src wraps
        cfg(2'd0, 16'hFFFF); cfg(2'd1, 16'd6);
        cfg(2'd2, 16'h00FF); cfg(2'd3, 16'd1);
        pulse_drq(2'b10);
        repeat (4) @(negedge clk);
        chk("R2 channel 1 alone idle", 32'(hold_req), 32'd0);
        chk("R9 channel 1 pending", 32'(req_pending), 32'b10);
        nbytes = 0;
        pulse_drq(2'b01);
        wait_start();
        cfg(2'd0, 16'h1234);
        wait_end();
        chk("R5 byte count run2", 32'(nbytes), 32'd2);
        chk("R8 busy write ignored src_addr", 32'(src_addr), 32'h0001);
        chk("R4 wrap src_count", 32'(src_count), 32'h0004);
        chk("R4 dst_addr", 32'(dst_addr), 32'h0101);
        chk("R6 requests cleared run2", 32'(req_pending), 32'b00);

        // run 3: both counts zero, single byte
        cfg(2'd0, 16'h0010); cfg(2'd1, 16'd0);
        cfg(2'd2, 16'h0020); cfg(2'd3, 16'd0);
        nbytes = 0;
        pulse_drq(2'b01);
        wait_start();
        wait_end();
        chk("R5 byte count run3", 32'(nbytes), 32'd1);
        chk("R6 tc run3", 32'(tc_flags), 32'b11);
        chk("R8 final counts run3", 32'({src_count, dst_count}), 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule